// File: doc/BRIEF.md
# Two-Stage Watchdog with Bark and Bite

This block is a supervisory timer that software must service at regular intervals. Once armed, it counts a programmed number of seconds in a first stage. If no service arrives before that stage runs out, the block enters a barked condition. In that condition a status bit reads 1 and a level interrupt is raised. A second stage then counts a further programmed interval. If that stage also expires, the block emits a single-cycle reset request tagged with a 3-bit reset-type code. Counting advances only on a one-cycle seconds strobe supplied from outside.

Software controls the block through a byte-wide register port (address, write data, write enable, combinational read data). To get a pre-timeout of P seconds within a total timeout of T seconds, software writes T−P to the first-stage timer and P to the second-stage timer. The state machine has four states:

- **OFF**: disabled. Counters are held at their reload values.
- **STAGE1**: counting toward the bark.
- **STAGE2**: barked, counting toward the bite.
- **SPENT**: bitten and idle.

The transitions are:

- **arm**: OFF→STAGE1 when the enable bit is set.
- **pet**: any enabled state→STAGE1 on a service write.
- **bark**: STAGE1→STAGE2 when the first stage expires.
- **bite**: STAGE2→SPENT when the second stage expires, pulsing the reset request.
- **disarm**: any state→OFF when the enable bit is cleared.

Top module: `wdog_bark_bite`

## Requirements
- R1: After reset, the registers read: first-stage timer 32, second-stage timer 0, reset type 7, enable 0. The bark status, bark_irq, rst_req and rst_kind are all 0.
- R2: Register map, with unused bits reading 0:
  - 0x54 holds the 7-bit first-stage timer in bits 6:0.
  - 0x55 holds the 7-bit second-stage timer in bits 6:0.
  - 0x56 holds the 3-bit reset type in bits 2:0 (1 = warm, 4 = shutdown, 7 = hard).
  - 0x57 holds the enable in bit 7.
  - 0x58 always reads 0.
  - Any unmapped address reads 0.
- R3: After arm or pet, the bark occurs on seconds strobe number max(S1,1), where S1 is the first-stage value, and not before.
- R4: While barked (STAGE2 or SPENT), bit 6 of the status register at 0x10 and bark_irq both read 1. In OFF and STAGE1 both read 0.
- R5: The bite occurs on strobe number max(S2,1) after the bark, where S2 is the second-stage value. On the bite, rst_req is high for exactly one cycle and rst_kind carries the reset type during that cycle. At all other times rst_kind is 0.
- R6: After the bite, further strobes produce no reset request, and the bark status stays at 1.
- R7: Writing 1 to bit 0 of 0x58 while enabled restarts stage one in full and clears the bark. While disabled, the same write has no effect.
- R8: Clearing bit 7 of 0x57 clears the bark and stops counting. Setting it again restarts stage one in full.
- R9: Writes to the timer registers take effect only at the next arm or pet. An interval already running is unaffected.
- R10: Counters change only on a seconds strobe. Without strobes, the block never barks.
- R11: Writing bit 7 of 0x57 as 1 while already enabled does not restart counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sec_tick | input | 1 | one-cycle seconds strobe |
| reg_addr | input | 8 | register address |
| reg_wdata | input | 8 | register write data |
| reg_we | input | 1 | register write enable |
| reg_rdata | output | 8 | register read data, combinational from reg_addr |
| bark_irq | output | 1 | bark interrupt, level |
| rst_req | output | 1 | single-cycle reset request on bite |
| rst_kind | output | 3 | reset type code during rst_req, else 0 |

## Verification
The bench sweeps every pairing of small first- and second-stage values, including 0 in each stage. A design that took 0 literally would bark or bite a strobe early, or never. A design with an off-by-one in the reload would miss the exact strobe the sweep checks. Further directed cases cover the following, each of which would show as an unexpected bark, bite or pulse length:
- a mid-interval timer write, which a design would wrongly apply at once;
- a redundant enable write, which a design would wrongly treat as a restart;
- a service write while disabled, which a design would wrongly act on;
- strobes after the bite, which a design would wrongly re-arm on.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_STAGE1 = 2'd1,
        WD_STAGE2 = 2'd2,
        WD_SPENT  = 2'd3
    } wd_state_e;

    localparam logic [7:0] A_STATUS = 8'h10;
    localparam logic [7:0] A_TMR1   = 8'h54;
    localparam logic [7:0] A_TMR2   = 8'h55;
    localparam logic [7:0] A_KIND   = 8'h56;
    localparam logic [7:0] A_ARM    = 8'h57;
    localparam logic [7:0] A_PET    = 8'h58;
    localparam int         BARK_BIT = 6;
    localparam int         ARM_BIT  = 7;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int TW       = 7,
    parameter int KW       = 3,
    parameter int DEF_S1   = 32,
    parameter int DEF_S2   = 0,
    parameter int DEF_KIND = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          we,
    input  logic          bark,
    output logic [TW-1:0] s1_val,
    output logic [TW-1:0] s2_val,
    output logic [KW-1:0] kind_val,
    output logic          armed,
    output logic          arm_cmd,
    output logic          disarm_cmd,
    output logic          pet_cmd,
    output logic [7:0]    rdata
);
    logic wr_arm;

    assign wr_arm     = we && (addr == A_ARM);
    assign arm_cmd    = wr_arm && wdata[ARM_BIT] && !armed;
    assign disarm_cmd = wr_arm && !wdata[ARM_BIT];
    assign pet_cmd    = we && (addr == A_PET) && wdata[0] && armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_val   <= TW'(DEF_S1);
            s2_val   <= TW'(DEF_S2);
            kind_val <= KW'(DEF_KIND);
            armed    <= 1'b0;
        end else if (we) begin
            unique case (addr)
                A_TMR1:  s1_val   <= wdata[TW-1:0];
                A_TMR2:  s2_val   <= wdata[TW-1:0];
                A_KIND:  kind_val <= wdata[KW-1:0];
                A_ARM:   armed    <= wdata[ARM_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        unique case (addr)
            A_STATUS: rdata[BARK_BIT] = bark;
            A_TMR1:   rdata = 8'(s1_val);
            A_TMR2:   rdata = 8'(s2_val);
            A_KIND:   rdata = 8'(kind_val);
            A_ARM:    rdata[ARM_BIT] = armed;
            default:  rdata = 8'h00;
        endcase
    end

    // R7: a service write while disarmed must leave the block disarmed
    p_pet_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PET && !armed && !(wr_arm)) |=> !armed);
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int TW = 7,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          arm_cmd,
    input  logic          disarm_cmd,
    input  logic          pet_cmd,
    input  logic [TW-1:0] s1_val,
    input  logic [TW-1:0] s2_val,
    input  logic [KW-1:0] kind_val,
    output logic          bark,
    output logic          rst_req,
    output logic [KW-1:0] rst_kind
);
    localparam logic [TW-1:0] ONE = TW'(1);

    wd_state_e     state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] s2cap_q, s2cap_d;
    logic          bite_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        s2cap_d = s2cap_q;
        bite_d  = 1'b0;
        if (disarm_cmd) begin
            state_d = WD_OFF;
            cnt_d   = s1_val;
        end else if (arm_cmd || pet_cmd) begin
            state_d = WD_STAGE1;
            cnt_d   = s1_val;
            s2cap_d = s2_val;
        end else begin
            unique case (state_q)
                WD_OFF:    cnt_d = s1_val;
                WD_STAGE1: if (tick) begin
                    if (cnt_q <= ONE) begin
                        state_d = WD_STAGE2;
                        cnt_d   = s2cap_q;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                WD_STAGE2: if (tick) begin
                    if (cnt_q <= ONE) begin
                        state_d = WD_SPENT;
                        bite_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                WD_SPENT:  ;
                default:   state_d = WD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
            s2cap_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            s2cap_q <= s2cap_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            rst_kind <= '0;
        end else begin
            rst_req  <= bite_d;
            rst_kind <= bite_d ? kind_val : '0;
        end
    end

    assign bark = (state_q == WD_STAGE2) || (state_q == WD_SPENT);

    // R5: the reset request never lasts more than one cycle
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R5: a bite only happens from the barked condition
    p_req_barked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> bark);
    // R3: the bark only begins on a seconds strobe
    p_bark_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bark) |-> $past(tick));
    // R8: disarming drops the bark
    p_disarm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_cmd |=> !bark);
    // R7: servicing drops the bark
    p_pet_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pet_cmd && !disarm_cmd) |=> !bark);
    // R10: a running count holds when no strobe arrives
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == WD_STAGE1 || state_q == WD_STAGE2) && !tick
         && !arm_cmd && !pet_cmd && !disarm_cmd) |=> $stable(cnt_q));
    // R6: once spent, no further request without a restart
    p_spent_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_SPENT && !arm_cmd && !pet_cmd) |=> !rst_req);
endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite
    import wdog_pkg::*;
#(
    parameter int TW       = 7,
    parameter int KW       = 3,
    parameter int DEF_S1   = 32,
    parameter int DEF_S2   = 0,
    parameter int DEF_KIND = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [7:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          reg_we,
    output logic [7:0]    reg_rdata,
    output logic          bark_irq,
    output logic          rst_req,
    output logic [KW-1:0] rst_kind
);
    logic [TW-1:0] s1_val, s2_val;
    logic [KW-1:0] kind_val;
    logic          armed, arm_cmd, disarm_cmd, pet_cmd, bark;

    wdog_regs #(
        .TW(TW), .KW(KW), .DEF_S1(DEF_S1), .DEF_S2(DEF_S2), .DEF_KIND(DEF_KIND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .bark(bark), .s1_val(s1_val), .s2_val(s2_val), .kind_val(kind_val),
        .armed(armed), .arm_cmd(arm_cmd), .disarm_cmd(disarm_cmd),
        .pet_cmd(pet_cmd), .rdata(reg_rdata)
    );

    wdog_fsm #(.TW(TW), .KW(KW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .arm_cmd(arm_cmd),
        .disarm_cmd(disarm_cmd), .pet_cmd(pet_cmd), .s1_val(s1_val),
        .s2_val(s2_val), .kind_val(kind_val), .bark(bark),
        .rst_req(rst_req), .rst_kind(rst_kind)
    );

    assign bark_irq = bark;

    // R4: a barked block is always armed (disarm clears it in the same edge)
    p_bark_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bark |-> armed);
endmodule

// File: tb/test_wdog_bark_bite.sv
module test_wdog_bark_bite;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       bark_irq, rst_req;
    logic [2:0] rst_kind;
    int checks = 0;
    int fails = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_bark_bite i_wdog_bark_bite (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .bark_irq(bark_irq), .rst_req(rst_req), .rst_kind(rst_kind)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h54, rv); chk("R1 tmr1", rv, 32);
        rd(8'h55, rv); chk("R1 tmr2", rv, 0);
        rd(8'h56, rv); chk("R1 kind", rv, 7);
        rd(8'h57, rv); chk("R1 arm", rv, 0);
        rd(8'h10, rv); chk("R1 status", rv, 0);
        chk("R1 irq", bark_irq, 0);
        chk("R1 req", rst_req, 0);
        chk("R1 kind out", rst_kind, 0);

        // R2 field widths and readback
        wr(8'h54, 8'hFF); rd(8'h54, rv); chk("R2 tmr1 width", rv, 8'h7F);
        wr(8'h56, 8'hFC); rd(8'h56, rv); chk("R2 kind width", rv, 4);
        wr(8'h58, 8'h01); rd(8'h58, rv); chk("R2 pet reads 0", rv, 0);
        rd(8'h33, rv); chk("R2 unmapped", rv, 0);

        // R10 no strobes, no bark
        wr(8'h54, 8'd1); wr(8'h57, 8'h80);
        repeat (50) @(negedge clk);
        chk("R10 no tick no bark", bark_irq, 0);

        // R3 R4 R5 sweep
        for (int s1 = 0; s1 <= 4; s1++) begin
            for (int s2 = 0; s2 <= 3; s2++) begin
                int e1, e2, kd;
                e1 = (s1 == 0) ? 1 : s1;
                e2 = (s2 == 0) ? 1 : s2;
                kd = ((s1 + s2) % 3 == 0) ? 1 : (((s1 + s2) % 3 == 1) ? 4 : 7);
                wr(8'h57, 8'h00);
                wr(8'h54, 8'(s1)); wr(8'h55, 8'(s2)); wr(8'h56, 8'(kd));
                wr(8'h57, 8'h80);
                for (int k = 1; k <= e1; k++) begin
                    tick();
                    chk("R3 bark timing", bark_irq, (k == e1) ? 1 : 0);
                end
                rd(8'h10, rv); chk("R4 status bit6", rv, 8'h40);
                for (int j = 1; j <= e2; j++) begin
                    tick();
                    chk("R5 bite timing", rst_req, (j == e2) ? 1 : 0);
                    if (j == e2) chk("R5 kind", rst_kind, kd);
                end
                @(negedge clk);
                chk("R5 pulse width", rst_req, 0);
                chk("R5 kind idle", rst_kind, 0);
            end
        end

        // R6 after bite
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R6 no second bite", rst_req, 0);
        end
        chk("R6 bark held", bark_irq, 1);

        // R7 pet clears and restarts (S1=4, S2=3 loaded)
        wr(8'h58, 8'h01);
        chk("R7 pet clears bark", bark_irq, 0);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R7 full stage one", bark_irq, (k == 4) ? 1 : 0);
        end
        // R8 disarm clears and stops
        wr(8'h57, 8'h00);
        chk("R8 disarm clears", bark_irq, 0);
        wr(8'h58, 8'h01);
        for (int k = 0; k < 6; k++) tick();
        chk("R7 pet while off ignored", bark_irq, 0);
        rd(8'h57, rv); chk("R7 still disarmed", rv, 0);
        chk("R8 stopped", bark_irq, 0);
        wr(8'h54, 8'd2); wr(8'h57, 8'h80);
        tick(); chk("R8 rearm full", bark_irq, 0);
        tick(); chk("R8 rearm bark", bark_irq, 1);

        // R9 timer write mid-run deferred
        wr(8'h57, 8'h00); wr(8'h54, 8'd3); wr(8'h57, 8'h80);
        tick();
        wr(8'h54, 8'd1);
        tick(); chk("R9 old value kept", bark_irq, 0);
        tick(); chk("R9 old value bark", bark_irq, 1);
        wr(8'h58, 8'h01);
        tick(); chk("R9 new value at pet", bark_irq, 1);

        // R11 redundant arm write
        wr(8'h57, 8'h00); wr(8'h54, 8'd3); wr(8'h57, 8'h80);
        tick(); tick();
        wr(8'h57, 8'h80);
        tick(); chk("R11 no restart", bark_irq, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule